// File: doc/BRIEF.md
# Private-Interrupt Configuration Register Block

This block holds the per-CPU configuration of 32 private interrupts. Interrupts 0–15 are software-generated. Interrupts 16–31 come from peripheral input lines. A register port reaches the block, and every request on that port carries a secure attribute. The block keeps the following state:

- group and group-modifier bits
- a non-secure access-control word
- enable, pending and active bitmaps, each with a set address and a clear address
- one 8-bit priority per interrupt
- one trigger-mode bit per interrupt
- a sleep handshake
- two 64-bit base-address registers

The enable, pending, active, group, trigger and priority state is driven continuously to the downstream pending and arbitration logic.

Secure and non-secure requests see the same registers in different ways. While security is enabled, a non-secure request can reach only the bits of group-1 interrupts. It also sees priorities through a one-bit-shifted window. A global security-disable input removes this split.

The port accepts one request per clock and has no back-pressure: there is no ready signal. Every request gets a response exactly one cycle later, and the consumer must always accept it. Writes also produce a response, with zero data.

Top module: `ral_redist_regs`

## Requirements
- R1: While `sec_disable`=0, a non-secure request to any enable, pending, active or trigger-config address is masked bit-for-bit by the group register (1 = group 1). Masked bits read 0 and are left unchanged by writes.
- R2: The set addresses are enable 0x84, pending 0x8C and active 0x94. The matching clear address is the set address plus 4. A set write ORs the masked data into the bitmap, and a clear write removes the masked data bits. Both addresses read the same masked bitmap.
- R3: While security is enabled, a non-secure priority read of a group-1 interrupt returns (stored<<1)&0xFF. A non-secure write stores 0x80|(data>>1). For group-0 interrupts, the non-secure view reads 0 and ignores writes.
- R4: Priorities sit at byte addresses 0xC0+n for interrupt n. A byte access carries one priority in data[7:0]. A word access at a 4-aligned address covers four interrupts, with the lowest-numbered one in data[7:0].
- R5: The trigger bit is 1 for edge and 0 for level. Bits 0–15 are always 1. A word read at 0x9C or 0xA0 returns the low or high 16 trigger bits, with trigger bit k placed at data bit 2k+1. Writes to 0x9C are ignored. A write to 0xA0 loads trigger bit 16+k from data bit 2k+1, subject to the R1 mask.
- R6: The group register (0x80) can be accessed by secure requests, or by any request while security is disabled. The group-modifier register (0xA4) and the access-control register (0xA8) can be accessed only by secure requests while security is enabled. Outside these cases the register reads 0 and ignores writes.
- R7: The wake register is at 0x04. Only bit 1 (sleep request) is writable. Bit 2 (asleep) always equals bit 1, with no delay.
- R8: The pending view is the pending latch ORed with the registered input level of every level-triggered interrupt. A rising edge on an edge-triggered peripheral line sets its pending latch. That bit is visible on `irq_pending` one cycle after the input is sampled high.
- R9: Base register b (b = 0 or 1) sits at 0x10+8b. It is reachable as a doubleword, or as words at +0 (low half) and +4 (high half). The words at 0x00 and 0x08/0x0C and the doubleword at 0x08 return the ID and type parameters and ignore writes. Any other offset or size combination reads 0 and ignores writes.
- R10: `rsp_valid` is high exactly in the cycle after each cycle with `acc_valid` high, and `rsp_rdata` carries the read data in that cycle.
- R11: After reset, the following state is 0: bitmaps, priorities, group (all interrupts group 0), group modifier, access control, peripheral trigger bits, sleep bit and base registers.
- R12: `state_update` pulses for one cycle, together with `rsp_valid`, after any write to a word address from 0x80 to 0xA8, or after a valid priority write. No other write raises it.
- R13: With `sec_disable`=1, non-secure requests see the bitmaps and priorities unmasked and unshifted. Registers reserved for secure requests still read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_disable | input | 1 | Global security disable |
| ppi_level | input | 16 | Peripheral interrupt input lines (interrupts 16–31) |
| acc_valid | input | 1 | Request present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_secure | input | 1 | Request attribute: secure |
| acc_size | input | 2 | 0 byte, 2 word, 3 doubleword |
| acc_addr | input | 8 | Byte offset |
| acc_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Read data (0 for writes) |
| irq_group | output | 32 | Group bits |
| irq_group_mod | output | 32 | Group-modifier bits |
| irq_enable | output | 32 | Enable bitmap |
| irq_pending | output | 32 | Pending view (latch OR level) |
| irq_active | output | 32 | Active bitmap |
| irq_edge | output | 32 | Trigger mode, 1 = edge |
| irq_prio | output | 256 | Priorities, interrupt n at bits 8n+7:8n |
| state_update | output | 1 | One-cycle strobe after an interrupt-state write |

## Verification
A fault in the group mask or in the security qualifiers changes what a non-secure read returns. It shows up on `rsp_rdata` one cycle after the request, and also on `irq_enable` or `irq_prio` one cycle after an illegal write. A fault in the latch for the peripheral lines or in the trigger bits is visible on `irq_pending` one cycle after the line changes. A fault in byte-lane placement corrupts the neighbouring priorities of a word access, and reading the word back exposes it.

// File: rtl/ral_pkg.sv
package ral_pkg;
  localparam int NIRQ = 32;
  localparam int NPPI = NIRQ / 2;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd2;
  localparam logic [1:0] SZ_DWORD = 2'd3;

  localparam logic [7:0] A_ID      = 8'h00;
  localparam logic [7:0] A_WAKE    = 8'h04;
  localparam logic [7:0] A_TYPE    = 8'h08;
  localparam logic [7:0] A_BASE    = 8'h10;
  localparam logic [7:0] A_GROUP   = 8'h80;
  localparam logic [7:0] A_SET0    = 8'h84;  // set/clear pairs at +8 stride
  localparam logic [7:0] A_CFG_LO  = 8'h9C;
  localparam logic [7:0] A_CFG_HI  = 8'hA0;
  localparam logic [7:0] A_GRPMOD  = 8'hA4;
  localparam logic [7:0] A_NSAC    = 8'hA8;

  // place bit k of a half-word at bit 2k+1 of a word
  function automatic logic [31:0] spread16(input logic [15:0] v);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < 16; k++) r[2*k+1] = v[k];
    return r;
  endfunction

  function automatic logic [15:0] squeeze16(input logic [31:0] v);
    logic [15:0] r;
    for (int k = 0; k < 16; k++) r[k] = v[2*k+1];
    return r;
  endfunction
endpackage

// File: rtl/ral_bitmap.sv
module ral_bitmap #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] clr_bits,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_bits) | set_bits | hw_set;
  end

  // R2: bits named by a clear write are gone next cycle
  p_clear_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_bits) |=> ((q & $past(clr_bits & ~set_bits & ~hw_set)) == '0));
  // R2: bits named by a set write are present next cycle
  p_set_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_bits) |=> ((q & $past(set_bits)) == $past(set_bits)));
endmodule

// File: rtl/ral_prio_bank.sv
module ral_prio_bank #(
  parameter int NIRQ = 32,
  parameter int PW   = 8,
  localparam int IW  = $clog2(NIRQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              ns_view,
  input  logic [NIRQ-1:0]   group,
  input  logic [IW-1:0]     first,
  input  logic              quad,
  input  logic [4*PW-1:0]   wdata,
  output logic [4*PW-1:0]   rdata,
  output logic [NIRQ*PW-1:0] prio_flat
);
  logic [PW-1:0] prio_q [NIRQ];

  for (genvar g = 0; g < NIRQ; g++) begin : g_slot
    logic [IW-1:0] off;
    logic          hit;
    logic [PW-1:0] lane, nxt;
    assign off  = IW'(g) - first;
    assign hit  = quad ? (off < IW'(4)) : (off == '0);
    assign lane = wdata[off[1:0]*PW +: PW];
    assign nxt  = ns_view ? {1'b1, lane[PW-1:1]} : lane;

    always_ff @(posedge clk) begin
      if (!rst_n) prio_q[g] <= '0;
      else if (wr_en && hit && (!ns_view || group[g])) prio_q[g] <= nxt;
    end
    assign prio_flat[g*PW +: PW] = prio_q[g];

    // R3: a restricted write never alters a group-0 priority
    p_secure_prio_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ns_view && !group[g]) |=> $stable(prio_q[g]));
  end

  always_comb begin
    logic [IW-1:0] idx;
    logic [PW-1:0] v;
    rdata = '0;
    for (int j = 0; j < 4; j++) begin
      idx = first + IW'(j);
      v   = prio_q[idx];
      if (j == 0 || quad)
        rdata[j*PW +: PW] = !ns_view ? v : (group[idx] ? {v[PW-2:0], 1'b0} : '0);
    end
  end
endmodule

// File: rtl/ral_redist_regs.sv
module ral_redist_regs import ral_pkg::*; #(
  parameter logic [31:0] ID_VALUE   = 32'h5244_0103,
  parameter logic [63:0] TYPE_VALUE = 64'h0000_0001_0000_0010,
  parameter int          NBASE      = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_disable,
  input  logic [NPPI-1:0]    ppi_level,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic               acc_secure,
  input  logic [1:0]         acc_size,
  input  logic [7:0]         acc_addr,
  input  logic [63:0]        acc_wdata,
  output logic               rsp_valid,
  output logic [63:0]        rsp_rdata,
  output logic [NIRQ-1:0]    irq_group,
  output logic [NIRQ-1:0]    irq_group_mod,
  output logic [NIRQ-1:0]    irq_enable,
  output logic [NIRQ-1:0]    irq_pending,
  output logic [NIRQ-1:0]    irq_active,
  output logic [NIRQ-1:0]    irq_edge,
  output logic [NIRQ*8-1:0]  irq_prio,
  output logic               state_update
);
  localparam int NBM = 3;

  logic is_b, is_w, is_d, wr_w, ns_restrict, sec_only, grp_ok, in_prio, prio_ok;
  logic [NIRQ-1:0] gmask, group_q, grpmod_q, nsac_q, edge_full, pend_hw, pend_view;
  logic [NPPI-1:0] edge_q, lvl_q;
  logic            sleep_q, upd_q;
  logic [63:0]     base_q [NBASE];
  logic [63:0]     rmux;
  logic [31:0]     prio_rd;
  logic [NIRQ-1:0] bm_set [NBM], bm_clr [NBM], bm_hw [NBM], bm_q [NBM];

  assign is_b        = acc_size == SZ_BYTE;
  assign is_w        = acc_size == SZ_WORD;
  assign is_d        = acc_size == SZ_DWORD;
  assign wr_w        = acc_valid && acc_write && is_w;
  assign ns_restrict = !acc_secure && !sec_disable;
  assign sec_only    = acc_secure && !sec_disable;
  assign grp_ok      = acc_secure || sec_disable;
  assign gmask       = ns_restrict ? group_q : '1;
  assign in_prio     = acc_addr[7:5] == 3'b110;
  assign prio_ok     = in_prio && (is_b || (is_w && acc_addr[1:0] == 2'b00));
  assign edge_full   = {edge_q, {NPPI{1'b1}}};
  assign pend_hw     = {ppi_level & ~lvl_q, {NPPI{1'b0}}} & edge_full;
  assign pend_view   = bm_q[1] | ({lvl_q, {NPPI{1'b0}}} & ~edge_full);

  // enable / pending / active bitmaps share one structure
  for (genvar b = 0; b < NBM; b++) begin : g_bm
    assign bm_set[b] = (wr_w && acc_addr == A_SET0 + 8'(8*b))        ? acc_wdata[31:0] & gmask : '0;
    assign bm_clr[b] = (wr_w && acc_addr == A_SET0 + 8'(8*b) + 8'd4) ? acc_wdata[31:0] & gmask : '0;
    if (b == 1) begin : g_hw
      assign bm_hw[b] = pend_hw;
    end else begin : g_nohw
      assign bm_hw[b] = '0;
    end
    ral_bitmap #(.W(NIRQ)) u_bm (
      .clk(clk), .rst_n(rst_n), .set_bits(bm_set[b]), .clr_bits(bm_clr[b]),
      .hw_set(bm_hw[b]), .q(bm_q[b]));
  end

  ral_prio_bank #(.NIRQ(NIRQ), .PW(8)) u_prio (
    .clk(clk), .rst_n(rst_n), .wr_en(acc_valid && acc_write && prio_ok),
    .ns_view(ns_restrict), .group(group_q), .first(acc_addr[4:0]), .quad(is_w),
    .wdata(acc_wdata[31:0]), .rdata(prio_rd), .prio_flat(irq_prio));

  for (genvar b = 0; b < NBASE; b++) begin : g_base
    localparam logic [7:0] BA = A_BASE + 8'(8*b);
    always_ff @(posedge clk) begin
      if (!rst_n) base_q[b] <= '0;
      else if (acc_valid && acc_write) begin
        if (is_d && acc_addr == BA)              base_q[b]        <= acc_wdata;
        else if (is_w && acc_addr == BA)         base_q[b][31:0]  <= acc_wdata[31:0];
        else if (is_w && acc_addr == BA + 8'd4)  base_q[b][63:32] <= acc_wdata[31:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      group_q <= '0; grpmod_q <= '0; nsac_q <= '0; edge_q <= '0;
      sleep_q <= 1'b0; lvl_q <= '0; upd_q <= 1'b0;
    end else begin
      lvl_q <= ppi_level;
      upd_q <= acc_valid && acc_write &&
               (prio_ok || (is_w && acc_addr >= A_GROUP && acc_addr <= A_NSAC));
      if (wr_w) begin
        if (acc_addr == A_GROUP && grp_ok)    group_q  <= acc_wdata[31:0];
        if (acc_addr == A_GRPMOD && sec_only) grpmod_q <= acc_wdata[31:0];
        if (acc_addr == A_NSAC && sec_only)   nsac_q   <= acc_wdata[31:0];
        if (acc_addr == A_WAKE)               sleep_q  <= acc_wdata[1];
        if (acc_addr == A_CFG_HI)
          edge_q <= (edge_q & ~gmask[NIRQ-1:NPPI]) | (squeeze16(acc_wdata[31:0]) & gmask[NIRQ-1:NPPI]);
      end
    end
  end

  always_comb begin
    rmux = '0;
    if (is_w) begin
      case (acc_addr)
        A_ID:                 rmux[31:0] = ID_VALUE;
        A_WAKE:               rmux[2:0]  = {sleep_q, sleep_q, 1'b0};
        A_TYPE:               rmux[31:0] = TYPE_VALUE[31:0];
        A_TYPE + 8'd4:        rmux[31:0] = TYPE_VALUE[63:32];
        A_GROUP:              rmux[31:0] = grp_ok ? group_q : '0;
        8'h84, 8'h88:         rmux[31:0] = bm_q[0] & gmask;
        8'h8C, 8'h90:         rmux[31:0] = pend_view & gmask;
        8'h94, 8'h98:         rmux[31:0] = bm_q[2] & gmask;
        A_CFG_LO:             rmux[31:0] = spread16(edge_full[NPPI-1:0] & gmask[NPPI-1:0]);
        A_CFG_HI:             rmux[31:0] = spread16(edge_full[NIRQ-1:NPPI] & gmask[NIRQ-1:NPPI]);
        A_GRPMOD:             rmux[31:0] = sec_only ? grpmod_q : '0;
        A_NSAC:               rmux[31:0] = sec_only ? nsac_q : '0;
        default:              rmux = '0;
      endcase
    end else if (is_d && acc_addr == A_TYPE) begin
      rmux = TYPE_VALUE;
    end
    for (int b = 0; b < NBASE; b++) begin
      if (is_d && acc_addr == A_BASE + 8'(8*b))         rmux = base_q[b];
      if (is_w && acc_addr == A_BASE + 8'(8*b))         rmux = {32'h0, base_q[b][31:0]};
      if (is_w && acc_addr == A_BASE + 8'(8*b) + 8'd4)  rmux = {32'h0, base_q[b][63:32]};
    end
    if (prio_ok) rmux = {32'h0, prio_rd};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_rdata <= (acc_valid && !acc_write) ? rmux : '0;
    end
  end

  assign irq_group     = group_q;
  assign irq_group_mod = grpmod_q;
  assign irq_enable    = bm_q[0];
  assign irq_pending   = pend_view;
  assign irq_active    = bm_q[2];
  assign irq_edge      = edge_full;
  assign state_update  = upd_q;

  // R10: a response follows each request and only a request
  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);
  p_rsp_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid);
  // R1: restricted writes leave group-0 enable bits untouched
  p_ns_enable_guard_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && ns_restrict) |=>
      (((irq_enable ^ $past(irq_enable)) & ~$past(irq_group)) == '0));
  // R7: the sleep bit tracks the last wake write
  p_wake_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_w && acc_addr == A_WAKE) |=> (sleep_q == $past(acc_wdata[1])));
  // R12: the strobe only ever follows a write
  p_update_after_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    state_update |-> $past(acc_valid && acc_write));
endmodule

// File: tb/tb_ral_redist_regs.sv
module tb_ral_redist_regs;
  localparam logic [31:0] IDV = 32'h5244_0103;
  localparam logic [63:0] TYV = 64'h0000_0001_0000_0010;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic rst_n, sec_disable, acc_valid, acc_write, acc_secure;
  logic [15:0] ppi_level;
  logic [1:0]  acc_size;
  logic [7:0]  acc_addr;
  logic [63:0] acc_wdata, rsp_rdata;
  logic        rsp_valid, state_update;
  logic [31:0] irq_group, irq_group_mod, irq_enable, irq_pending, irq_active, irq_edge;
  logic [255:0] irq_prio;

  ral_redist_regs dut (
    .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable), .ppi_level(ppi_level),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_secure(acc_secure),
    .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_group(irq_group),
    .irq_group_mod(irq_group_mod), .irq_enable(irq_enable), .irq_pending(irq_pending),
    .irq_active(irq_active), .irq_edge(irq_edge), .irq_prio(irq_prio),
    .state_update(state_update));

  int n_tests = 0, n_fail = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic s, input logic [1:0] sz,
                     input logic [7:0] a, input logic [63:0] d, output logic [63:0] r);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_secure = s; acc_size = sz;
    acc_addr = a; acc_wdata = d;
    @(negedge clk);
    r = rsp_rdata;
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic        sec;
    logic [1:0]  sz;
    logic [7:0]  addr;
    logic [63:0] data;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 64;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,2'd2,8'h80,64'hFFFF0000,64'h0,4'd6},          // R6
    '{1'b0,1'b0,2'd2,8'h80,64'h0,64'h0,4'd6},                 // R6 ns group RAZ
    '{1'b0,1'b1,2'd2,8'h80,64'h0,64'hFFFF0000,4'd6},
    '{1'b1,1'b0,2'd2,8'h84,64'hFFFFFFFF,64'h0,4'd1},          // R1
    '{1'b0,1'b1,2'd2,8'h84,64'h0,64'hFFFF0000,4'd1},
    '{1'b1,1'b1,2'd2,8'h84,64'h0000000F,64'h0,4'd2},          // R2
    '{1'b0,1'b0,2'd2,8'h88,64'h0,64'hFFFF0000,4'd1},
    '{1'b0,1'b1,2'd2,8'h88,64'h0,64'hFFFF000F,4'd2},
    '{1'b1,1'b0,2'd2,8'h88,64'h00030003,64'h0,4'd1},
    '{1'b0,1'b1,2'd2,8'h84,64'h0,64'hFFFC000F,4'd1},
    '{1'b1,1'b1,2'd2,8'hC0,64'h44332211,64'h0,4'd4},          // R4
    '{1'b0,1'b0,2'd2,8'hC0,64'h0,64'h0,4'd3},                 // R3
    '{1'b1,1'b0,2'd0,8'hD0,64'h40,64'h0,4'd3},
    '{1'b0,1'b1,2'd0,8'hD0,64'h0,64'hA0,4'd3},
    '{1'b0,1'b0,2'd0,8'hD0,64'h0,64'h40,4'd3},
    '{1'b1,1'b0,2'd0,8'hC1,64'hFF,64'h0,4'd3},
    '{1'b0,1'b1,2'd2,8'hC0,64'h0,64'h44332211,4'd3},
    '{1'b1,1'b1,2'd2,8'hD4,64'h80604020,64'h0,4'd4},
    '{1'b0,1'b1,2'd2,8'hD4,64'h0,64'h80604020,4'd4},
    '{1'b0,1'b0,2'd2,8'hD4,64'h0,64'h00C08040,4'd3},
    '{1'b0,1'b1,2'd0,8'hD5,64'h0,64'h40,4'd4},
    '{1'b0,1'b1,2'd2,8'h9C,64'h0,64'hAAAAAAAA,4'd5},          // R5
    '{1'b0,1'b1,2'd2,8'hA0,64'h0,64'h0,4'd5},
    '{1'b1,1'b1,2'd2,8'h9C,64'h0,64'h0,4'd5},
    '{1'b0,1'b1,2'd2,8'h9C,64'h0,64'hAAAAAAAA,4'd5},
    '{1'b1,1'b0,2'd2,8'hA0,64'h0000000A,64'h0,4'd5},
    '{1'b0,1'b1,2'd2,8'hA0,64'h0,64'h0000000A,4'd5},
    '{1'b0,1'b0,2'd2,8'h9C,64'h0,64'h0,4'd1},
    '{1'b1,1'b1,2'd2,8'hA4,64'h12345678,64'h0,4'd6},
    '{1'b0,1'b1,2'd2,8'hA4,64'h0,64'h12345678,4'd6},
    '{1'b1,1'b0,2'd2,8'hA4,64'h0,64'h0,4'd6},
    '{1'b0,1'b0,2'd2,8'hA4,64'h0,64'h0,4'd6},
    '{1'b0,1'b1,2'd2,8'hA4,64'h0,64'h12345678,4'd6},
    '{1'b1,1'b1,2'd2,8'hA8,64'hA5A5A5A5,64'h0,4'd6},
    '{1'b0,1'b1,2'd2,8'hA8,64'h0,64'hA5A5A5A5,4'd6},
    '{1'b0,1'b0,2'd2,8'hA8,64'h0,64'h0,4'd6},
    '{1'b1,1'b0,2'd2,8'h04,64'hFFFFFFFF,64'h0,4'd7},          // R7
    '{1'b0,1'b1,2'd2,8'h04,64'h0,64'h6,4'd7},
    '{1'b1,1'b1,2'd2,8'h04,64'h0,64'h0,4'd7},
    '{1'b0,1'b1,2'd2,8'h04,64'h0,64'h0,4'd7},
    '{1'b1,1'b1,2'd3,8'h10,64'h1122334455667788,64'h0,4'd9}, // R9
    '{1'b0,1'b1,2'd2,8'h10,64'h0,64'h55667788,4'd9},
    '{1'b0,1'b1,2'd2,8'h14,64'h0,64'h11223344,4'd9},
    '{1'b1,1'b1,2'd2,8'h1C,64'hDEADBEEF,64'h0,4'd9},
    '{1'b0,1'b1,2'd3,8'h18,64'h0,64'hDEADBEEF00000000,4'd9},
    '{1'b0,1'b1,2'd2,8'h00,64'h0,{32'h0,IDV},4'd9},
    '{1'b1,1'b1,2'd2,8'h00,64'h0,64'h0,4'd9},
    '{1'b0,1'b1,2'd2,8'h00,64'h0,{32'h0,IDV},4'd9},
    '{1'b1,1'b1,2'd3,8'h08,64'h0,64'h0,4'd9},
    '{1'b0,1'b1,2'd3,8'h08,64'h0,TYV,4'd9},
    '{1'b0,1'b1,2'd2,8'h0C,64'h0,{32'h0,TYV[63:32]},4'd9},
    '{1'b0,1'b1,2'd2,8'h60,64'h0,64'h0,4'd9},
    '{1'b1,1'b1,2'd0,8'h84,64'hFF,64'h0,4'd9},
    '{1'b0,1'b1,2'd2,8'h84,64'h0,64'hFFFC000F,4'd9},
    '{1'b0,1'b1,2'd3,8'h80,64'h0,64'h0,4'd9},
    '{1'b1,1'b0,2'd2,8'h8C,64'hFFFFFFFF,64'h0,4'd2},          // R2 pending
    '{1'b0,1'b1,2'd2,8'h90,64'h0,64'hFFFF0000,4'd2},
    '{1'b1,1'b1,2'd2,8'h90,64'hFFFFFFFF,64'h0,4'd2},
    '{1'b0,1'b1,2'd2,8'h8C,64'h0,64'h0,4'd2},
    '{1'b1,1'b1,2'd2,8'h94,64'h00000001,64'h0,4'd2},
    '{1'b0,1'b0,2'd2,8'h98,64'h0,64'h0,4'd1},
    '{1'b0,1'b1,2'd2,8'h98,64'h0,64'h1,4'd2},
    '{1'b1,1'b1,2'd2,8'h98,64'h1,64'h0,4'd2},
    '{1'b0,1'b1,2'd2,8'h94,64'h0,64'h0,4'd2}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] r;
    rst_n = 1'b0; sec_disable = 1'b0; ppi_level = '0; acc_valid = 1'b0; acc_write = 1'b0;
    acc_secure = 1'b0; acc_size = 2'd2; acc_addr = '0; acc_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 enable", {32'h0, irq_enable}, 64'h0);
    chk("R11 pending", {32'h0, irq_pending}, 64'h0);
    chk("R11 group", {32'h0, irq_group}, 64'h0);
    chk("R11 edge", {32'h0, irq_edge}, 64'h0000FFFF);
    chk("R11 prio", {63'h0, |irq_prio}, 64'h0);
    chk("R10 idle rsp", {62'h0, rsp_valid, state_update}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      acc(VECS[i].wr, VECS[i].sec, VECS[i].sz, VECS[i].addr, VECS[i].data, r);
      if (!VECS[i].wr) chk($sformatf("R%0d vector %0d", VECS[i].req, i), r, VECS[i].exp);
    end

    // R8 level-triggered line (interrupt 18)
    @(negedge clk); ppi_level = 16'h0004;
    @(negedge clk); chk("R8 level pending", {63'h0, irq_pending[18]}, 64'h1);
    acc(1'b0, 1'b1, 2'd2, 8'h8C, 64'h0, r);
    chk("R8 level read", r, 64'h00040000);
    ppi_level = 16'h0000;
    @(negedge clk); chk("R8 level drop", {63'h0, irq_pending[18]}, 64'h0);
    // R8 edge-triggered line (interrupt 16)
    ppi_level = 16'h0001;
    @(negedge clk); chk("R8 edge latch", {63'h0, irq_pending[16]}, 64'h1);
    ppi_level = 16'h0000;
    @(negedge clk); chk("R8 edge held", {63'h0, irq_pending[16]}, 64'h1);
    acc(1'b1, 1'b1, 2'd2, 8'h90, 64'h00010000, r);
    chk("R8 edge cleared", {32'h0, irq_pending}, 64'h0);

    // R12 / R10 strobe and response timing
    acc(1'b1, 1'b1, 2'd2, 8'h84, 64'h00000100, r);
    chk("R12 update after enable write", {63'h0, state_update}, 64'h1);
    chk("R10 rsp after write", {63'h0, rsp_valid}, 64'h1);
    @(negedge clk);
    chk("R12 update one cycle", {63'h0, state_update}, 64'h0);
    chk("R10 rsp one cycle", {63'h0, rsp_valid}, 64'h0);
    acc(1'b1, 1'b1, 2'd2, 8'h10, 64'h5, r);
    chk("R12 no update on base write", {63'h0, state_update}, 64'h0);

    chk("R3 prio port", {56'h0, irq_prio[16*8 +: 8]}, 64'hA0);
    chk("R5 edge port", {32'h0, irq_edge}, 64'h0003FFFF);
    chk("R6 grpmod port", {32'h0, irq_group_mod}, 64'h12345678);

    // R13 security disabled
    sec_disable = 1'b1;
    acc(1'b0, 1'b0, 2'd2, 8'hA4, 64'h0, r);
    chk("R13 grpmod hidden", r, 64'h0);
    acc(1'b0, 1'b0, 2'd2, 8'h80, 64'h0, r);
    chk("R13 group visible", r, 64'hFFFF0000);
    acc(1'b1, 1'b0, 2'd2, 8'h88, 64'hFFFFFFFF, r);
    chk("R13 unmasked clear", {32'h0, irq_enable}, 64'h0);
    acc(1'b1, 1'b0, 2'd0, 8'hC0, 64'h12, r);
    acc(1'b0, 1'b0, 2'd0, 8'hC0, 64'h0, r);
    chk("R13 unshifted prio", r, 64'h12);
    sec_disable = 1'b0;

    // R11 reset clears written state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    acc(1'b0, 1'b1, 2'd2, 8'hA0, 64'h0, r);
    chk("R11 cfg after reset", r, 64'h0);
    acc(1'b0, 1'b1, 2'd3, 8'h10, 64'h0, r);
    chk("R11 base after reset", r, 64'h0);
    chk("R11 prio after reset", {63'h0, |irq_prio}, 64'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule